// File: doc/BRIEF.md
# Serial Controller Host Register Front End

This block sits between a processor bus and the character-level side of an asynchronous serial controller. The processor sees four byte-wide registers selected by a two-bit address: two control registers, a status register and a data register. The bus is wired in inverted polarity, so every byte written is complemented before it is stored and every byte read is complemented before it is driven out.

Outgoing characters are held in a transmit holding register. They are shaped to the configured character length, with an optional parity bit for 7-bit characters, and are offered on a byte-wide valid/ready port. Incoming characters arrive on a byte-wide valid port with framing and parity error qualifiers. They land in a receive holding register, and the data-ready, overrun, framing and parity flags are kept alongside them. Two modem inputs, data-set-ready and carrier-detect, are mirrored into status and any change on them is latched as a modem-change event. Three level interrupts report transmit-empty, receive data ready and modem change. Bit serialization, baud generation, break, loop and echo are outside this block. The loop, break, stop-bit and echo control bits are only stored.

Top module: `sio_regfront`

## Requirements
- R1: The bus is inverted. The value on bus_wdata is complemented before it is stored, and bus_rdata always carries the complement of the register that bus_addr selects. After reset, control 1, control 2 and the received byte read as 0x00 in true polarity, and status reads 0x41 (bit 0 transmit-empty and bit 6 DSR set). irq_tx is 1, irq_rx and irq_modem are 0, and tx_valid is 0.
- R2: Address 0 is control 1 and address 1 is control 2. Both read back exactly what was written. Control 1 bits: 3 parity-check enable, 2 receiver enable, 1 transmitter enable, 0 modem-interrupt enable. Control 2 bits: 7:6 character length (00 = 8 bits, 01 = 7, 10 = 6, 11 = 5), and 4 odd parity when 1, even when 0.
- R3: A write to address 3 stores the character with all bits above the configured length cleared.
- R4: When the length is 7 bits and parity-check enable is set, bit 7 of the stored character is a parity bit. With odd parity selected, bit 7 makes the total count of ones in the byte odd; with even parity selected, it makes that count even. For any other length, or with parity-check enable clear, no parity bit is added.
- R5: A write to address 3 clears transmit-empty (status bit 0). The character is offered (tx_valid) only while transmit-empty is clear and the transmitter enable is set. A cycle with tx_valid and tx_ready both high sets transmit-empty again. irq_tx equals transmit-empty.
- R6: With the receiver enabled, an arriving character is stored and sets data ready (status bit 1). irq_rx equals data ready. Reading address 3 returns the stored byte and clears data ready.
- R7: A character that arrives while data ready is still set sets the overrun flag (status bit 2), replaces the stored byte, and leaves data ready set.
- R8: Writing control 1 with the receiver enable clear clears the framing, parity, overrun and data-ready flags. Characters that arrive while the receiver is disabled are discarded, and the stored byte is unchanged.
- R9: An accepted character with rx_frame_err set sets the framing flag (status bit 4). An accepted character with rx_par_err set sets the parity flag (status bit 3), but only while parity-check enable is set. Both flags are sticky until cleared under R8.
- R10: Status bits 6 and 5 mirror dsr_in and dcd_in one cycle late. Any change on either input sets the modem-change flag (status bit 7), and reading status clears that flag.
- R11: irq_modem is high exactly while the modem-change flag and the control 1 modem-interrupt enable are both set.
- R12: A write to address 2 has no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe; read side effects occur at the clock edge |
| bus_addr | input | ADDR_W | Register select |
| bus_wdata | input | DATA_W | Inverted write data |
| bus_rdata | output | DATA_W | Inverted read data for the addressed register |
| tx_data | output | DATA_W | Character offered to the transmitter |
| tx_valid | output | 1 | Character offered |
| tx_ready | input | 1 | Transmitter accepts the offered character |
| rx_data | input | DATA_W | Received character |
| rx_valid | input | 1 | Received character present this cycle |
| rx_frame_err | input | 1 | Framing error qualifier of rx_data |
| rx_par_err | input | 1 | Parity error qualifier of rx_data |
| dsr_in | input | 1 | Data-set-ready modem line |
| dcd_in | input | 1 | Carrier-detect modem line |
| irq_rx | output | 1 | Receive interrupt level |
| irq_tx | output | 1 | Transmit interrupt level |
| irq_modem | output | 1 | Modem-change interrupt level |

## Verification
A wrong flag in this block shows up in two places. It appears on one of the interrupt levels in the cycle after the causing edge, and it appears in the complemented status byte at the next read. The bench compares every status read and interrupt level against values worked out from the requirement text. A character shaped wrongly appears on tx_data in the cycle after the data write. The bench therefore sweeps every byte value through every length and parity setting, predicts each character arithmetically, and checks it before the handshake completes.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef enum logic [1:0] {
      REG_CTL1 = 2'd0,
      REG_CTL2 = 2'd1,
      REG_STAT = 2'd2,
      REG_DATA = 2'd3
   } reg_sel_e;

   // control 1 field positions
   localparam int C1_DTR  = 0;
   localparam int C1_TXEN = 1;
   localparam int C1_RXEN = 2;
   localparam int C1_PCHK = 3;

   // control 2 field positions
   localparam int C2_ODD  = 4;
   localparam int C2_LENL = 6;
   localparam int C2_LENH = 7;

   // length code that selects seven-bit characters
   localparam logic [1:0] LEN_SEVEN = 2'b01;

   typedef struct packed {
      logic chg;
      logic dsr;
      logic dcd;
      logic fe;
      logic pe;
      logic ovr;
      logic dr;
      logic empty;
   } stat_t;

endpackage

// File: rtl/sio_tx_hold.sv
module sio_tx_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] load_byte,
   input  logic [1:0]    len_sel,
   input  logic          par_en,
   input  logic          par_odd,
   input  logic          tx_en,
   input  logic          tx_ready,
   output logic [DW-1:0] tx_data,
   output logic          tx_valid,
   output logic          empty
);
   import sio_pkg::*;

   localparam int LENW = $clog2(DW) + 1;

   logic [LENW-1:0] width;
   logic [DW-1:0]   keep;
   logic [DW-1:0]   masked;
   logic [DW-1:0]   shaped;
   logic            par_bit;
   logic [DW-1:0]   hold_q;
   logic            empty_q;

   assign width = LENW'(DW) - LENW'(len_sel);

   for (genvar i = 0; i < DW; i++) begin : g_keep
      assign keep[i] = (LENW'(i) < width);
   end

   assign masked  = load_byte & keep;
   assign par_bit = (^masked[DW-2:0]) ^ par_odd;

   always_comb begin
      shaped = masked;
      if (par_en && (len_sel == LEN_SEVEN)) begin
         shaped[DW-1] = par_bit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q  <= '0;
         empty_q <= 1'b1;
      end else if (load) begin
         hold_q  <= shaped;
         empty_q <= 1'b0;
      end else if (tx_valid && tx_ready) begin
         empty_q <= 1'b1;
      end
   end

   assign tx_data  = hold_q;
   assign tx_valid = !empty_q && tx_en;
   assign empty    = empty_q;

endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arrive,
   input  logic [DW-1:0] arrive_byte,
   input  logic          frame_err,
   input  logic          par_err,
   input  logic          rx_en,
   input  logic          chk_par,
   input  logic          take,
   input  logic          wipe,
   output logic [DW-1:0] rbuf,
   output logic          dr,
   output logic          ovr,
   output logic          fe,
   output logic          pe
);

   logic accept;
   assign accept = arrive && rx_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rbuf <= '0;
         dr   <= 1'b0;
         ovr  <= 1'b0;
         fe   <= 1'b0;
         pe   <= 1'b0;
      end else if (wipe) begin
         dr  <= 1'b0;
         ovr <= 1'b0;
         fe  <= 1'b0;
         pe  <= 1'b0;
      end else if (accept) begin
         rbuf <= arrive_byte;
         dr   <= 1'b1;
         if (dr && !take) ovr <= 1'b1;
         fe <= fe | frame_err;
         pe <= pe | (par_err & chk_par);
      end else if (take) begin
         dr <= 1'b0;
      end
   end

endmodule

// File: rtl/sio_modem_watch.sv
module sio_modem_watch (
   input  logic clk,
   input  logic rst_n,
   input  logic dsr_in,
   input  logic dcd_in,
   input  logic ack,
   output logic dsr_q,
   output logic dcd_q,
   output logic chg
);

   logic moved;
   assign moved = (dsr_in != dsr_q) || (dcd_in != dcd_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dsr_q <= 1'b1;
         dcd_q <= 1'b0;
         chg   <= 1'b0;
      end else begin
         dsr_q <= dsr_in;
         dcd_q <= dcd_in;
         if (moved)    chg <= 1'b1;
         else if (ack) chg <= 1'b0;
      end
   end

endmodule

// File: rtl/sio_regfront.sv
module sio_regfront #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_valid,
   input  logic              rx_frame_err,
   input  logic              rx_par_err,
   input  logic              dsr_in,
   input  logic              dcd_in,
   output logic              irq_rx,
   output logic              irq_tx,
   output logic              irq_modem
);
   import sio_pkg::*;

   if (DATA_W != 8) begin : g_bad_width
      $error("sio_regfront: DATA_W must be 8");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("sio_regfront: ADDR_W must be 2");
   end

   reg_sel_e          sel;
   logic [DATA_W-1:0] wbyte;
   logic [DATA_W-1:0] ctrl1_q;
   logic [DATA_W-1:0] ctrl2_q;
   logic              ctl1_wr;
   logic              ctl2_wr;
   logic              data_wr;
   logic              data_rd;
   logic              stat_rd;
   logic              rx_wipe;
   logic [DATA_W-1:0] rx_buf;
   logic              st_dr;
   logic              st_ovr;
   logic              st_fe;
   logic              st_pe;
   logic              st_empty;
   logic              st_dsr;
   logic              st_dcd;
   logic              st_chg;
   stat_t             stat;
   logic [DATA_W-1:0] rd_true;

   assign sel     = reg_sel_e'(bus_addr);
   assign wbyte   = ~bus_wdata;
   assign ctl1_wr = bus_wr && (sel == REG_CTL1);
   assign ctl2_wr = bus_wr && (sel == REG_CTL2);
   assign data_wr = bus_wr && (sel == REG_DATA);
   assign data_rd = bus_rd && (sel == REG_DATA);
   assign stat_rd = bus_rd && (sel == REG_STAT);
   assign rx_wipe = ctl1_wr && !wbyte[C1_RXEN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl1_q <= '0;
         ctrl2_q <= '0;
      end else begin
         if (ctl1_wr) ctrl1_q <= wbyte;
         if (ctl2_wr) ctrl2_q <= wbyte;
      end
   end

   sio_tx_hold #(.DW(DATA_W)) i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (data_wr),
      .load_byte (wbyte),
      .len_sel   (ctrl2_q[C2_LENH:C2_LENL]),
      .par_en    (ctrl1_q[C1_PCHK]),
      .par_odd   (ctrl2_q[C2_ODD]),
      .tx_en     (ctrl1_q[C1_TXEN]),
      .tx_ready  (tx_ready),
      .tx_data   (tx_data),
      .tx_valid  (tx_valid),
      .empty     (st_empty)
   );

   sio_rx_hold #(.DW(DATA_W)) i_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .arrive      (rx_valid),
      .arrive_byte (rx_data),
      .frame_err   (rx_frame_err),
      .par_err     (rx_par_err),
      .rx_en       (ctrl1_q[C1_RXEN]),
      .chk_par     (ctrl1_q[C1_PCHK]),
      .take        (data_rd),
      .wipe        (rx_wipe),
      .rbuf        (rx_buf),
      .dr          (st_dr),
      .ovr         (st_ovr),
      .fe          (st_fe),
      .pe          (st_pe)
   );

   sio_modem_watch i_modem (
      .clk    (clk),
      .rst_n  (rst_n),
      .dsr_in (dsr_in),
      .dcd_in (dcd_in),
      .ack    (stat_rd),
      .dsr_q  (st_dsr),
      .dcd_q  (st_dcd),
      .chg    (st_chg)
   );

   always_comb begin
      stat.chg   = st_chg;
      stat.dsr   = st_dsr;
      stat.dcd   = st_dcd;
      stat.fe    = st_fe;
      stat.pe    = st_pe;
      stat.ovr   = st_ovr;
      stat.dr    = st_dr;
      stat.empty = st_empty;
   end

   always_comb begin
      unique case (sel)
         REG_CTL1: rd_true = ctrl1_q;
         REG_CTL2: rd_true = ctrl2_q;
         REG_STAT: rd_true = stat;
         REG_DATA: rd_true = rx_buf;
         default:  rd_true = '0;
      endcase
   end

   assign bus_rdata = ~rd_true;
   assign irq_tx    = st_empty;
   assign irq_rx    = st_dr;
   assign irq_modem = st_chg && ctrl1_q[C1_DTR];

endmodule

// File: rtl/sio_regfront_chk.sv
module sio_regfront_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       irq_tx,
   input logic       irq_rx,
   input logic       irq_modem,
   input logic       rx_valid,
   input logic       data_wr,
   input logic       data_rd,
   input logic       wipe,
   input logic [7:0] ctl1,
   input logic       ovr,
   input logic       dsr_in,
   input logic       dcd_in,
   input logic       dsr_q,
   input logic       dcd_q,
   input logic       dsc
);

   assert_empty_not_offered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tx |-> !tx_valid);

   assert_offer_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> ctl1[1]);

   assert_accept_sets_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && !data_wr) |=> irq_tx);

   assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !irq_tx);

   assert_read_clears_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !(rx_valid && ctl1[2])) |=> !irq_rx);

   assert_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && ctl1[2] && irq_rx && !data_rd && !wipe) |=> (ovr && irq_rx));

   assert_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (!irq_rx && !ovr));

   assert_modem_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((dsr_in != dsr_q) || (dcd_in != dcd_q)) |=> dsc);

   assert_modem_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_modem |-> (ctl1[0] && dsc));

endmodule

bind sio_regfront sio_regfront_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_valid  (tx_valid),
   .tx_ready  (tx_ready),
   .irq_tx    (irq_tx),
   .irq_rx    (irq_rx),
   .irq_modem (irq_modem),
   .rx_valid  (rx_valid),
   .data_wr   (data_wr),
   .data_rd   (data_rd),
   .wipe      (rx_wipe),
   .ctl1      (ctrl1_q),
   .ovr       (st_ovr),
   .dsr_in    (dsr_in),
   .dcd_in    (dcd_in),
   .dsr_q     (st_dsr),
   .dcd_q     (st_dcd),
   .dsc       (st_chg)
);

// File: tb/test_sio_regfront.sv
`timescale 1ns/1ps
module test_sio_regfront;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'hFF;
   logic [7:0] bus_rdata;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic       rx_valid = 1'b0;
   logic       rx_frame_err = 1'b0;
   logic       rx_par_err = 1'b0;
   logic       dsr_in = 1'b1;
   logic       dcd_in = 1'b0;
   logic       irq_rx;
   logic       irq_tx;
   logic       irq_modem;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #2.5 clk = ~clk;

   sio_regfront i_sio_regfront (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_rd       (bus_rd),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .tx_data      (tx_data),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .rx_data      (rx_data),
      .rx_valid     (rx_valid),
      .rx_frame_err (rx_frame_err),
      .rx_par_err   (rx_par_err),
      .dsr_in       (dsr_in),
      .dcd_in       (dcd_in),
      .irq_rx       (irq_rx),
      .irq_tx       (irq_tx),
      .irq_modem    (irq_modem)
   );

   task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // true-polarity write
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = ~d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 8'hFF;
   endtask

   // true-polarity read; side effect lands at the following edge
   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = ~bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic arrive(input logic [7:0] d, input logic fe, input logic pe);
      @(negedge clk);
      rx_valid = 1'b1; rx_data = d; rx_frame_err = fe; rx_par_err = pe;
      @(negedge clk);
      rx_valid = 1'b0; rx_frame_err = 1'b0; rx_par_err = 1'b0;
   endtask

   function automatic logic [7:0] shape(input int d, input int len, input bit pchk, input bit odd);
      int bits = 8 - len;
      int v = d & ((1 << bits) - 1);
      int ones = 0;
      if (bits == 7 && pchk) begin
         for (int k = 0; k < 7; k++) ones += (v >> k) & 1;
         if (odd  && (ones % 2 == 0)) v |= 8'h80;
         if (!odd && (ones % 2 == 1)) v |= 8'h80;
      end
      return v[7:0];
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, read through the inverted bus
      rd(2'd0, r); check("R1 ctl1 reset", {1'b0, r}, 9'h000);
      rd(2'd1, r); check("R1 ctl2 reset", {1'b0, r}, 9'h000);
      rd(2'd2, r); check("R1 status reset", {1'b0, r}, 9'h041);
      rd(2'd3, r); check("R1 data reset", {1'b0, r}, 9'h000);
      check("R1 irq/valid reset", {5'd0, irq_tx, irq_rx, irq_modem, tx_valid}, 9'b0_0000_1000);

      // R2 control readback, R1 raw bus polarity
      wr(2'd0, 8'hA1);
      @(negedge clk); bus_addr = 2'd0; #1;
      check("R1 raw rdata inverted", {1'b0, bus_rdata}, 9'h05E);
      rd(2'd0, r); check("R2 ctl1 readback", {1'b0, r}, 9'h0A1);
      wr(2'd1, 8'h3C);
      rd(2'd1, r); check("R2 ctl2 readback", {1'b0, r}, 9'h03C);

      // R12 write to status address does nothing
      wr(2'd2, 8'h00);
      wr(2'd2, 8'hFF);
      rd(2'd2, r); check("R12 status unaffected", {1'b0, r}, 9'h041);
      rd(2'd0, r); check("R12 ctl1 unaffected", {1'b0, r}, 9'h0A1);
      check("R12 irqs unaffected", {6'd0, irq_tx, irq_rx, irq_modem}, 9'b100);

      // R3 R4 R5 sweep of every byte over every length and parity setting
      for (int len = 0; len < 4; len++) begin
         for (int pf = 0; pf < 4; pf++) begin
            bit pchk = pf[0];
            bit odd  = pf[1];
            wr(2'd0, 8'h02 | (pchk ? 8'h08 : 8'h00));
            wr(2'd1, 8'(len << 6) | (odd ? 8'h10 : 8'h00));
            for (int d = 0; d < 256; d++) begin
               wr(2'd3, 8'(d));
               check("R3 R4 shaped char offered", {tx_valid, tx_data}, {1'b1, shape(d, len, pchk, odd)});
               check("R5 write clears empty", {8'd0, irq_tx}, 9'd0);
               tx_ready = 1'b1;
               @(negedge clk);
               tx_ready = 1'b0;
               check("R5 accept sets empty", {7'd0, irq_tx, tx_valid}, 9'b10);
            end
         end
      end

      // R5 transmitter disabled holds the character
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      wr(2'd3, 8'h55);
      check("R5 no offer when disabled", {7'd0, tx_valid, irq_tx}, 9'b00);
      rd(2'd2, r); check("R5 status empty clear", {1'b0, r}, 9'h040);
      wr(2'd0, 8'h02);
      check("R5 offer after enable", {tx_valid, tx_data}, {1'b1, 8'h55});
      tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
      check("R5 accepted", {8'd0, irq_tx}, 9'd1);

      // R6 receive path
      wr(2'd0, 8'h04);
      arrive(8'h3C, 1'b0, 1'b0);
      check("R6 irq_rx follows ready", {8'd0, irq_rx}, 9'd1);
      rd(2'd2, r); check("R6 status ready", {1'b0, r}, 9'h043);
      rd(2'd3, r); check("R6 data read", {1'b0, r}, 9'h03C);
      check("R6 read clears ready", {8'd0, irq_rx}, 9'd0);

      // R7 overrun
      arrive(8'h11, 1'b0, 1'b0);
      arrive(8'h22, 1'b0, 1'b0);
      rd(2'd2, r); check("R7 overrun flagged", {1'b0, r}, 9'h047);
      rd(2'd3, r); check("R7 newest byte kept", {1'b0, r}, 9'h022);

      // R9 error capture
      arrive(8'h66, 1'b1, 1'b1);
      rd(2'd2, r); check("R9 frame set, parity ignored", {1'b0, r}, 9'h057);
      rd(2'd3, r);
      wr(2'd0, 8'h0C);
      arrive(8'h77, 1'b0, 1'b1);
      rd(2'd2, r); check("R9 parity error captured", {1'b0, r}, 9'h05F);

      // R8 wipe and discard
      wr(2'd0, 8'h00);
      rd(2'd2, r); check("R8 disable wipes flags", {1'b0, r}, 9'h041);
      check("R8 irq_rx cleared", {8'd0, irq_rx}, 9'd0);
      arrive(8'h99, 1'b1, 1'b0);
      check("R8 discarded no irq", {8'd0, irq_rx}, 9'd0);
      rd(2'd2, r); check("R8 discarded status", {1'b0, r}, 9'h041);
      rd(2'd3, r); check("R8 byte unchanged", {1'b0, r}, 9'h077);

      // R10 R11 modem lines
      wr(2'd0, 8'h01);
      @(negedge clk); dcd_in = 1'b1;
      @(negedge clk);
      check("R11 irq_modem on change", {8'd0, irq_modem}, 9'd1);
      rd(2'd2, r); check("R10 change and carrier", {1'b0, r}, 9'h0E1);
      check("R11 irq drops after ack", {8'd0, irq_modem}, 9'd0);
      rd(2'd2, r); check("R10 flag acknowledged", {1'b0, r}, 9'h061);
      wr(2'd0, 8'h00);
      @(negedge clk); dsr_in = 1'b0;
      @(negedge clk);
      check("R11 masked without enable", {8'd0, irq_modem}, 9'd0);
      rd(2'd2, r); check("R10 dsr drop seen", {1'b0, r}, 9'h0A1);
      rd(2'd2, r); check("R10 cleared again", {1'b0, r}, 9'h021);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule